// File: doc/BRIEF.md
# Atomic Set/Clear GPIO Port

This block is a general-purpose I/O port of up to 32 lines behind a 32-bit memory-mapped register interface. None of its control bits has a plain writable register. The output levels, the output enables and the per-line debounce enables each have one address that sets bits and another that clears them. Only the ones in the written word take effect. Several processors can therefore change different lines without a read-modify-write sequence, and no lock is needed.

The port drives the pad output value and the pad output enable directly from its registers. It also presents the debounce enables to an external filter. The pad input levels pass through a synchronizer and are then readable at a single address. Reads are combinational from the address while the read strobe is high. Writes take effect at the clock edge on which the write strobe is high.

Top module: `gpio_sc_port`

## Requirements
- R1: After reset, `pad_out`, `pad_oe` and `dbnc_en` are all zero, so every line is an input, and the direction readback at 0x018 returns zero.
- R2: A write to 0x000 sets each `pad_out` bit whose data bit is one. Bits written as zero keep their value.
- R3: A write to 0x004 clears each `pad_out` bit whose data bit is one. Bits written as zero keep their value. A bit that receives a set and a clear in the same cycle keeps its old value.
- R4: Writes to 0x010 set direction bits and writes to 0x014 clear them, with one-bits selecting lines. A direction bit of 1 means output, and `pad_oe` equals the direction bits. These writes do not change `pad_out`.
- R5: A read at 0x018 returns the current direction bits in bit positions 0 to N-1.
- R6: Writes to 0x060 set `dbnc_en` bits and writes to 0x064 clear them, with one-bits selecting lines.
- R7: A read at 0x080 returns `pad_in` through a two-flop synchronizer. A change on `pad_in` is not visible after one rising clock edge and is visible after the second.
- R8: Reads at the set and clear addresses (0x000, 0x004, 0x010, 0x014, 0x060, 0x064), and reads at any unmapped offset, return zero.
- R9: Writes to the read-only offsets 0x018 and 0x080, and to unmapped offsets, change neither `pad_out`, `pad_oe` nor `dbnc_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_rd | input | 1 | Read strobe; enables `bus_rdata` |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data (ones select lines) |
| bus_rdata | output | 32 | Read data, combinational, zero when no read |
| pad_in | input | NUM_LINES | Pad input levels (asynchronous) |
| pad_out | output | NUM_LINES | Pad output value |
| pad_oe | output | NUM_LINES | Pad output enable (1 = drive) |
| dbnc_en | output | NUM_LINES | Per-line debounce enable to the filter |

## Verification
The bench writes overlapping set and clear patterns and checks that bits written as zero survive. A design that acted as a plain register, or that inverted the clear mask, would wipe or flip lines it was never asked to touch. Cross-register isolation is probed too: a design with a decode slip would let a direction write or a write to a read-only offset alter the output or debounce bits. The input path is sampled one edge and then two edges after a pad change. This exposes a synchronizer that is too short or too long. Reads at the set and clear addresses must return zero, which catches a design that leaks a register value onto the bus.

// File: rtl/gpsc_pkg.sv
package gpsc_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned NREG   = 3;   // 0 data, 1 direction, 2 debounce
  localparam int unsigned IDX_DAT = 0;
  localparam int unsigned IDX_DIR = 1;
  localparam int unsigned IDX_DBN = 2;

  localparam logic [ADDR_W-1:0] OFS_DAT_SET = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_DAT_CLR = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_DIR_SET = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_DIR_CLR = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_DIR_RD  = 12'h018;
  localparam logic [ADDR_W-1:0] OFS_DBN_SET = 12'h060;
  localparam logic [ADDR_W-1:0] OFS_DBN_CLR = 12'h064;
  localparam logic [ADDR_W-1:0] OFS_EXT_RD  = 12'h080;

  // Next value of a set/clear register: conflicting bits hold.
  function automatic logic [WORD_W-1:0] sc_next(input logic [WORD_W-1:0] cur,
                                                input logic [WORD_W-1:0] s,
                                                input logic [WORD_W-1:0] c);
    return (cur | (s & ~c)) & ~(c & ~s);
  endfunction
endpackage

// File: rtl/gpsc_decode.sv
module gpsc_decode
  import gpsc_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic                     wr,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [WORD_W-1:0]        wdata,
  output logic [NREG-1:0][N-1:0]   set_m,
  output logic [NREG-1:0][N-1:0]   clr_m
);
  localparam logic [NREG-1:0][ADDR_W-1:0] SET_OFS = {OFS_DBN_SET, OFS_DIR_SET, OFS_DAT_SET};
  localparam logic [NREG-1:0][ADDR_W-1:0] CLR_OFS = {OFS_DBN_CLR, OFS_DIR_CLR, OFS_DAT_CLR};

  for (genvar g = 0; g < NREG; g++) begin : g_dec
    assign set_m[g] = (wr && addr == SET_OFS[g]) ? wdata[N-1:0] : '0;
    assign clr_m[g] = (wr && addr == CLR_OFS[g]) ? wdata[N-1:0] : '0;
  end
endmodule

// File: rtl/gpsc_screg.sv
module gpsc_screg
  import gpsc_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q
);
  logic [WORD_W-1:0] nxt_w;
  logic [N-1:0] set_only, clr_only, both_hit, touched;

  assign nxt_w    = sc_next(WORD_W'(q), WORD_W'(set_i), WORD_W'(clr_i));
  assign set_only = set_i & ~clr_i;
  assign clr_only = clr_i & ~set_i;
  assign both_hit = set_i & clr_i;
  assign touched  = set_i | clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt_w[N-1:0];
  end

  // R2
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_only) |=> ((q & $past(set_only)) == $past(set_only)));
  // R3
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_only) |=> ((q & $past(clr_only)) == '0));
  // R3
  both_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|both_hit) |=> ((q & $past(both_hit)) == ($past(q) & $past(both_hit))));
  // R2
  untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((q ^ $past(q)) & ~$past(touched)) == '0));
endmodule

// File: rtl/gpsc_sync.sv
module gpsc_sync #(
  parameter int unsigned N      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [STAGES-1:0][N-1:0] chain;
  logic [1:0] warm;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= d;
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
    end
  end
  assign q = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;

  if (STAGES == 2) begin : g_lat_chk
    // R7
    ext_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm >= 2'd2) |-> (q == $past(d, 2)));
  end
endmodule

// File: rtl/gpio_sc_port.sv
module gpio_sc_port
  import gpsc_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [WORD_W-1:0]    bus_rdata,
  input  logic [NUM_LINES-1:0] pad_in,
  output logic [NUM_LINES-1:0] pad_out,
  output logic [NUM_LINES-1:0] pad_oe,
  output logic [NUM_LINES-1:0] dbnc_en
);
  localparam int unsigned N = NUM_LINES;

  logic [NREG-1:0][N-1:0] set_m, clr_m, reg_q;
  logic [N-1:0] ext_q;
  logic [N-1:0] any_hit;

  gpsc_decode #(.N(N)) u_dec (
    .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .set_m(set_m), .clr_m(clr_m)
  );

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    gpsc_screg #(.N(N)) u_reg (
      .clk(clk), .rst_n(rst_n),
      .set_i(set_m[r]), .clr_i(clr_m[r]), .q(reg_q[r])
    );
  end

  gpsc_sync #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(ext_q)
  );

  assign pad_out = reg_q[IDX_DAT];
  assign pad_oe  = reg_q[IDX_DIR];
  assign dbnc_en = reg_q[IDX_DBN];

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        OFS_DIR_RD: bus_rdata[N-1:0] = reg_q[IDX_DIR];
        OFS_EXT_RD: bus_rdata[N-1:0] = ext_q;
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign any_hit = set_m[IDX_DAT] | clr_m[IDX_DAT] | set_m[IDX_DIR] | clr_m[IDX_DIR]
                 | set_m[IDX_DBN] | clr_m[IDX_DBN];

  // R5
  dir_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_DIR_RD) |-> (bus_rdata[N-1:0] == pad_oe));
  // R8
  set_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == OFS_DAT_SET || bus_addr == OFS_DIR_CLR)) |-> (bus_rdata == '0));
  // R9
  ro_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == OFS_DIR_RD || bus_addr == OFS_EXT_RD)) |=>
      ($stable(pad_out) && $stable(pad_oe) && $stable(dbnc_en)));
  // R9
  no_hit_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr) |-> (any_hit == '0));
endmodule

// File: tb/gpio_sc_port_test.sv
module gpio_sc_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [N-1:0] pad_in = '0, pad_out, pad_oe, dbnc_en;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_sc_port uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .dbnc_en(dbnc_en)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 pad_out", pad_out, 32'h0);
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 dbnc_en", dbnc_en, 32'h0);
    rd(12'h018, v); check("R1 dir readback", v, 32'h0);
  endtask

  task automatic t_data;
    wr(12'h000, 32'hA5A5_0F0F); check("R2 set from zero", pad_out, 32'hA5A5_0F0F);
    wr(12'h000, 32'h0000_00F0); check("R2 set keeps others", pad_out, 32'hA5A5_0FFF);
    wr(12'h004, 32'h0F00_000F); check("R3 clear selected", pad_out, 32'hA0A5_0FF0);
    wr(12'h004, 32'h0); check("R3 clear zero no change", pad_out, 32'hA0A5_0FF0);
  endtask

  task automatic t_dir;
    logic [31:0] v;
    wr(12'h010, 32'hFFFF_0000); check("R4 dir set oe", pad_oe, 32'hFFFF_0000);
    wr(12'h014, 32'h00FF_0000); check("R4 dir clear oe", pad_oe, 32'hFF00_0000);
    check("R4 data untouched by dir", pad_out, 32'hA0A5_0FF0);
    rd(12'h018, v); check("R5 dir readback", v, 32'hFF00_0000);
  endtask

  task automatic t_dbn;
    wr(12'h060, 32'h1234_5678); check("R6 dbnc set", dbnc_en, 32'h1234_5678);
    wr(12'h064, 32'h0000_5678); check("R6 dbnc clear", dbnc_en, 32'h1234_0000);
  endtask

  task automatic t_ext;
    logic [31:0] v;
    @(negedge clk); pad_in = 32'hCAFE_F00D;
    @(negedge clk); rd(12'h080, v); check("R7 one edge old", v, 32'h0);
    @(negedge clk); rd(12'h080, v); check("R7 two edges new", v, 32'hCAFE_F00D);
  endtask

  task automatic t_zero_reads;
    logic [31:0] v;
    rd(12'h000, v); check("R8 read data set", v, 32'h0);
    rd(12'h004, v); check("R8 read data clr", v, 32'h0);
    rd(12'h010, v); check("R8 read dir set", v, 32'h0);
    rd(12'h014, v); check("R8 read dir clr", v, 32'h0);
    rd(12'h060, v); check("R8 read dbnc set", v, 32'h0);
    rd(12'h064, v); check("R8 read dbnc clr", v, 32'h0);
    rd(12'h100, v); check("R8 read unmapped", v, 32'h0);
  endtask

  task automatic t_ro_writes;
    wr(12'h018, 32'hFFFF_FFFF);
    wr(12'h080, 32'hFFFF_FFFF);
    wr(12'h008, 32'hFFFF_FFFF);
    wr(12'h070, 32'hFFFF_FFFF);
    check("R9 pad_out unchanged", pad_out, 32'hA0A5_0FF0);
    check("R9 pad_oe unchanged", pad_oe, 32'hFF00_0000);
    check("R9 dbnc unchanged", dbnc_en, 32'h1234_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_data();
    t_dir();
    t_dbn();
    t_ext();
    t_zero_reads();
    t_ro_writes();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule